// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is a combinational arithmetic unit for a 32-bit integer datapath. Two operands and a 4-bit operation code go in. One result word comes out within the same cycle. There are no registers inside, and no status flags or carry are produced. The surrounding pipeline stage captures the result.

Each function has its own hardware unit, and all units run in parallel. A final selector keeps the one the operation code names. The units are:

- a shared adder/subtractor, which also produces the signed less-than bit;
- a logarithmic barrel shifter covering all three shift kinds;
- a multiplier that returns either half of the double-width product.

Codes that name no operation return zero.

Top module: `int_alu`

## Requirements
- R1: Code 0 returns opa + opb and code 12 returns opa - opb, both wrapping modulo 2^32 (0xFFFFFFFF + 1 gives 0).
- R2: Code 4 returns the bitwise XOR of the operands, code 6 the bitwise OR and code 7 the bitwise AND.
- R3: Code 2 returns 1 when opa is less than opb read as signed two's-complement values, and 0 otherwise; bits 31:1 are always zero.
- R4: Code 1 shifts opa left, code 5 shifts opa right filling with zeros, and code 13 shifts opa right filling with opa[31]. The amount is opb[4:0] only; opb[31:5] has no effect on the result.
- R5: Code 8 returns bits 31:0 of the product opa*opb.
- R6: Code 9 returns bits 63:32 of the product of opa and opb, both taken as signed.
- R7: Code 11 returns bits 63:32 of the product of opa and opb, both taken as unsigned.
- R8: Code 15 returns opb unchanged.
- R9: Codes 3, 10 and 14 return zero for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand; the value that is shifted |
| opb | input | 32 | Second operand; bits 4:0 give the shift amount |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Result of the selected operation, valid in the same cycle |

## Verification
Every operation code is swept over a grid of corner operands:

- 0 and 1;
- 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF;
- mixed bit patterns;
- shift words whose upper 27 bits are set.

Sign boundaries separate signed from unsigned comparison, arithmetic from logical right shift, and the signed from the unsigned high product. The set upper bits of the shift words show whether anything above opb[4:0] leaks into the amount. A set of fixed expected values, worked out by hand, checks the high-half products at 0x80000000 and 0xFFFFFFFF, wrap-around add and subtract, and the unused codes. These do not depend on the bench's own reference model.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 4'd0,
      OP_SHL   = 4'd1,
      OP_SLT   = 4'd2,
      OP_XOR   = 4'd4,
      OP_SHR   = 4'd5,
      OP_OR    = 4'd6,
      OP_AND   = 4'd7,
      OP_MUL   = 4'd8,
      OP_MULH  = 4'd9,
      OP_MULHU = 4'd11,
      OP_SUB   = 4'd12,
      OP_SRA   = 4'd13,
      OP_PASSB = 4'd15
   } alu_op_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         lt_signed
);
   logic [W-1:0] b_eff;

   assign b_eff = b ^ {W{sub}};
   assign sum   = a + b_eff + W'(sub);

   // valid only while sub is set: signs differ -> opa negative wins,
   // signs equal -> sign of the difference
   assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
   parameter int W  = 32,
   parameter int SW = $clog2(W)
) (
   input  logic [W-1:0]  a,
   input  logic [SW-1:0] amt,
   input  logic          left,
   input  logic          arith,
   output logic [W-1:0]  y
);
   logic [W-1:0]       pre;
   logic [SW:0][W-1:0] stg;
   logic               fill;

   assign fill = arith & ~left & a[W-1];

   // left shifts reuse the right-shift stages on a bit-reversed word
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign pre[i] = left ? a[W-1-i] : a[i];
      assign y[i]   = left ? stg[SW][W-1-i] : stg[SW][i];
   end

   assign stg[0] = pre;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
   end
endmodule

// File: rtl/int_alu_mul.sv
module int_alu_mul #(
   parameter int W      = 32,
   parameter bit SHARED = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         hi_sel,
   input  logic         signed_ops,
   output logic [W-1:0] y
);
   localparam int PW = 2 * W;

   logic [PW-1:0] prod;

   if (SHARED) begin : g_shared
      // one array; operand extension picks signed or unsigned
      logic ext_a;
      logic ext_b;
      assign ext_a = signed_ops & a[W-1];
      assign ext_b = signed_ops & b[W-1];
      assign prod  = {{W{ext_a}}, a} * {{W{ext_b}}, b};
   end else begin : g_split
      // two arrays in parallel; shorter select path, twice the area
      logic [PW-1:0] p_s;
      logic [PW-1:0] p_u;
      assign p_s  = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
      assign p_u  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      assign prod = signed_ops ? p_s : p_u;
   end

   assign y = hi_sel ? prod[PW-1:W] : prod[W-1:0];
endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int W          = 32,
   parameter bit SHARED_MUL = 1'b1
) (
   input  logic [W-1:0]    opa,
   input  logic [W-1:0]    opb,
   input  logic [OP_W-1:0] op_sel,
   output logic [W-1:0]    result
);
   localparam int SW = $clog2(W);

   if (W < 8) begin : g_chk_min
      $error("int_alu: W must be at least 8");
   end
   if ((W & (W - 1)) != 0) begin : g_chk_pow2
      $error("int_alu: W must be a power of two");
   end

   logic         do_sub;
   logic [W-1:0] as_sum;
   logic         lt_s;
   logic [W-1:0] sh_y;
   logic [W-1:0] mul_y;

   assign do_sub = (op_sel == OP_SUB) || (op_sel == OP_SLT);

   int_alu_addsub #(.W(W)) u_addsub (
      .a         (opa),
      .b         (opb),
      .sub       (do_sub),
      .sum       (as_sum),
      .lt_signed (lt_s)
   );

   int_alu_shift #(.W(W), .SW(SW)) u_shift (
      .a     (opa),
      .amt   (opb[SW-1:0]),
      .left  (op_sel == OP_SHL),
      .arith (op_sel == OP_SRA),
      .y     (sh_y)
   );

   int_alu_mul #(.W(W), .SHARED(SHARED_MUL)) u_mul (
      .a          (opa),
      .b          (opb),
      .hi_sel     ((op_sel == OP_MULH) || (op_sel == OP_MULHU)),
      .signed_ops (op_sel == OP_MULH),
      .y          (mul_y)
   );

   always_comb begin
      case (op_sel)
         OP_ADD, OP_SUB:          result = as_sum;
         OP_SHL, OP_SHR, OP_SRA:  result = sh_y;
         OP_SLT:                  result = {{(W-1){1'b0}}, lt_s};
         OP_XOR:                  result = opa ^ opb;
         OP_OR:                   result = opa | opb;
         OP_AND:                  result = opa & opb;
         OP_MUL, OP_MULH, OP_MULHU: result = mul_y;
         OP_PASSB:                result = opb;
         default:                 result = '0;
      endcase
   end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
   import int_alu_pkg::*;
#(
   parameter int W = 32
) (
   input logic [W-1:0]    opa,
   input logic [W-1:0]    opb,
   input logic [OP_W-1:0] op_sel,
   input logic [W-1:0]    result
);
   always_comb begin
      if (op_sel == OP_ADD) begin
         assert_add_sum_R1: assert (result == opa + opb);
      end
      if (op_sel == OP_XOR) begin
         assert_xor_bits_R2: assert ((result ^ opb) == opa);
      end
      if (op_sel == OP_SLT) begin
         assert_slt_single_bit_R3: assert (result[W-1:1] == '0);
      end
      if (op_sel == OP_SHL && opb[4:0] == 5'd0) begin
         assert_shift_zero_keeps_R4: assert (result == opa);
      end
      if (op_sel == OP_MUL) begin
         assert_mul_low_R5: assert (result == W'(opa * opb));
      end
      if (op_sel == OP_PASSB) begin
         assert_pass_b_R8: assert (result == opb);
      end
      if (op_sel == 4'd3 || op_sel == 4'd10 || op_sel == 4'd14) begin
         assert_unused_zero_R9: assert (result == '0);
      end
   end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
   .opa    (opa),
   .opb    (opb),
   .op_sel (op_sel),
   .result (result)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa   = '0;
   logic [31:0] opb   = '0;
   logic [3:0]  op_sel = '0;
   logic [31:0] result;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   item_t sbq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   int_alu dut (
      .opa    (opa),
      .opb    (opb),
      .op_sel (op_sel),
      .result (result)
   );

   function automatic logic [31:0] ref_model(input logic [3:0] op,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
      longint      sp;
      logic [63:0] up;
      case (op)
         4'd0:  return a + b;
         4'd12: return a - b;
         4'd1:  return a << b[4:0];
         4'd5:  return a >> b[4:0];
         4'd13: return $unsigned($signed(a) >>> b[4:0]);
         4'd2:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'd4:  return a ^ b;
         4'd6:  return a | b;
         4'd7:  return a & b;
         4'd8:  begin up = {32'd0, a} * {32'd0, b}; return up[31:0]; end
         4'd9:  begin
                   sp = longint'($signed(a)) * longint'($signed(b));
                   return sp[63:32];
                end
         4'd11: begin up = {32'd0, a} * {32'd0, b}; return up[63:32]; end
         4'd15: return b;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd12:        return "R1";
         4'd4, 4'd6, 4'd7:   return "R2";
         4'd2:               return "R3";
         4'd1, 4'd5, 4'd13:  return "R4";
         4'd8:               return "R5";
         4'd9:               return "R6";
         4'd11:              return "R7";
         4'd15:              return "R8";
         default:            return "R9";
      endcase
   endfunction

   task automatic drive_exp(input logic [3:0] op, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] exp,
                            input string req);
      item_t it;
      @(posedge clk);
      #1;
      op_sel = op;
      opa    = a;
      opb    = b;
      it.op = op; it.a = a; it.b = b; it.exp = exp; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic drive(input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b);
      drive_exp(op, a, b, ref_model(op, a, b), req_of(op));
   endtask

   // monitor: compares half a cycle after each drive
   always @(negedge clk) begin
      item_t it;
      if (sbq.size() > 0) begin
         it = sbq.pop_front();
         total++;
         if (result !== it.exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     it.req, it.op, it.a, it.b, result, it.exp);
         end
      end
   end

   logic [31:0] pats [10] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                             32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
                             32'hDEAD_BEEF, 32'hFFFF_FFE4, 32'h0000_003F,
                             32'hA5A5_0011};

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero inputs select add and give zero (R1)
      drive_exp(4'd0, 32'd0, 32'd0, 32'd0, "R1");
      // hand-computed corner values
      drive_exp(4'd0,  32'hFFFF_FFFF, 32'h1, 32'h0, "R1");
      drive_exp(4'd12, 32'h0, 32'h1, 32'hFFFF_FFFF, "R1");
      drive_exp(4'd2,  32'h8000_0000, 32'h7FFF_FFFF, 32'h1, "R3");
      drive_exp(4'd2,  32'h7FFF_FFFF, 32'h8000_0000, 32'h0, "R3");
      drive_exp(4'd13, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
      drive_exp(4'd5,  32'h8000_0000, 32'h0000_003F, 32'h1, "R4");
      drive_exp(4'd1,  32'h1, 32'h0000_0020, 32'h1, "R4");
      drive_exp(4'd8,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, "R5");
      drive_exp(4'd9,  32'h8000_0000, 32'h8000_0000, 32'h4000_0000, "R6");
      drive_exp(4'd9,  32'h8000_0000, 32'h7FFF_FFFF, 32'hC000_0000, "R6");
      drive_exp(4'd9,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R6");
      drive_exp(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R7");
      drive_exp(4'd11, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R7");
      drive_exp(4'd15, 32'h1234_5678, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R8");
      drive_exp(4'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R9");
      drive_exp(4'd10, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, "R9");
      drive_exp(4'd14, 32'hDEAD_BEEF, 32'h1, 32'h0, "R9");
      // full sweep of every code over the operand grid (R1..R9 by code)
      for (int op = 0; op < 16; op++) begin
         for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
               drive(4'(op), pats[i], pats[j]);
            end
         end
      end
      wait (sbq.size() == 0);
      @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule